// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a shared packet memory that is divided into equal pages of 2048 bytes, one page per packet number. With the default of four pages (8 KB) there are four packet numbers. A host command port allocates numbers, queues them for transmission, takes received packets off the receive queue, releases numbers and resets the whole allocator. The MAC side asks for pages for arriving frames and reports each finished transmission. The block does not hold the packet memory or any frame data.

Transmit and receive draw from one pool with no fixed split. A host-set reserve keeps a number of pages out of reach of receive traffic, so that the host can still allocate for transmit. Three queues of packet numbers are kept. The transmit queue is fed by the host, and the MAC drains it. The done queue returns finished transmit numbers to the host. The receive queue holds the numbers of received frames. The block reports the free and total page counts and the head of each queue. It drives allocation, receive and transmit-empty interrupts.

Top module: `pkt_page_alloc`

## Requirements
- R1: After hardware reset: mem_total reads 4, mem_free reads 4, all three queues are empty, busy is low, pnr_val is 0, and int_alloc, alloc_pend, int_rx, int_txe and rx_ack are low.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. busy is then high for exactly one cycle while the command runs. A cmd_valid offered while busy is high is ignored. Opcodes: 0 none, 1 allocate, 2 reset, 3 remove receive head, 4 remove and release receive head, 5 release pnr_val, 6 enqueue pnr_val, 7 remove done head.
- R3: An allocate runs in its busy cycle. If a page is free, the lowest-numbered free page is taken, and on the next edge alloc_pnum shows it and int_alloc rises. int_alloc clears when a later allocate runs without a grant. A host allocation has priority over a receive request in the same cycle.
- R4: An allocate that finds no free page sets alloc_pend. The request is retried every cycle and is granted, as in R3, as soon as a page becomes free.
- R5: mem_free is the number of unallocated pages and mem_total is the page count, both in units of one 2048-byte page.
- R6: A one-cycle rx_req is answered one cycle later by rx_ack. rx_ok is 1 only if the free pages left after any same-cycle host grant exceed rsv_pages. On a grant, rx_pnum is the lowest remaining free page and is appended to the receive queue.
- R7: int_rx equals the inverse of rx_empty at all times.
- R8: Enqueue appends pnr_val to the transmit queue. tx_done removes the transmit head and appends it to the done queue. Opcode 7 removes the done head. A push to a full queue is dropped, and a pop from an empty queue is ignored.
- R9: With auto_rel high, tx_done frees the page of the completed packet. With auto_rel low, the page stays allocated until a release command names it.
- R10: Opcode 4 pops the receive head and frees its page. Opcode 3 pops it without freeing the page.
- R11: The reset command frees every page, empties all queues, clears pnr_val, alloc_pend, int_alloc and int_txe, and blocks any allocation in that cycle.
- R12: int_txe rises when tx_done removes the last transmit-queue entry and no enqueue runs in that cycle. It clears when an enqueue runs.
- R13: pnr_val loads pnr_wdata on a pnr_we edge. A reset command in the same cycle takes priority and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Host command opcode |
| pnr_we | input | 1 | Load packet number register |
| pnr_wdata | input | 2 | Value for packet number register |
| rsv_pages | input | 3 | Pages held back from receive |
| auto_rel | input | 1 | Free pages on transmit completion |
| rx_req | input | 1 | MAC asks for a receive page |
| tx_done | input | 1 | MAC finished the transmit head |
| busy | output | 1 | Command executing |
| pnr_val | output | 2 | Packet number register |
| alloc_pnum | output | 2 | Last host-allocated number |
| alloc_pend | output | 1 | Host allocation waiting for a page |
| int_alloc | output | 1 | Allocation interrupt |
| int_rx | output | 1 | Receive interrupt |
| int_txe | output | 1 | Transmit-empty interrupt |
| rx_ack | output | 1 | Response to rx_req |
| rx_ok | output | 1 | Receive page granted |
| rx_pnum | output | 2 | Granted receive number |
| tx_empty | output | 1 | Transmit queue empty |
| tx_head | output | 2 | Transmit queue head |
| done_empty | output | 1 | Done queue empty |
| done_head | output | 2 | Done queue head |
| rx_empty | output | 1 | Receive queue empty |
| rx_head | output | 2 | Receive queue head |
| mem_total | output | 3 | Total pages |
| mem_free | output | 3 | Free pages |

## Verification
The assertions check several properties on every cycle. busy lasts one cycle, and a command it blocks is dropped. A receive grant never cuts the free count below the reserve it was checked against. Host and receive never take the same page. A waiting allocation resolves once a page is free. A granted receive shows up as a pending receive interrupt. A full queue holds its head against a push, and an empty queue stays empty on a pop. Only the bench scenarios can show the rest: which page is picked, the FIFO order of numbers across the three queues, the page freed under each auto_rel setting, the reserve boundary at equality, and the full cleanup done by the reset command.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_RXPOP    = 3'd3,
    OP_RXPOPREL = 3'd4,
    OP_RELEASE  = 3'd5,
    OP_ENQUEUE  = 3'd6,
    OP_DONEPOP  = 3'd7
  } host_op_e;
endpackage

// File: rtl/pn_fifo.sv
module pn_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         single
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop, do_push;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign single = (cnt_q == CW'(1));
  assign dout   = mem_q[rd_q];

  always_comb begin
    do_pop  = pop & ~empty;
    do_push = push & (~full | do_pop);
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_pop)  rd_d = rd_q + 1'b1;
      if (do_push) wr_d = wr_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && do_push) mem_q[wr_q] <= din;
  end

  // R8: a push into a full queue without a pop changes nothing visible
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && $stable(dout)));

  // R8: popping an empty queue leaves it empty
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/page_pool.sv
module page_pool #(
  parameter int NPAGE = 4,
  parameter int PN_W  = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             host_req,
  input  logic             rx_req,
  input  logic [CNT_W-1:0] rsv,
  input  logic [NPAGE-1:0] free_mask,
  output logic             host_gnt,
  output logic [PN_W-1:0]  host_pn,
  output logic             rx_gnt,
  output logic [PN_W-1:0]  rx_pn,
  output logic [CNT_W-1:0] free_cnt
);
  logic [NPAGE-1:0] used_q, used_d, host_mask, rx_mask;
  logic             host_hit, rx_hit;
  logic [CNT_W-1:0] avail;

  always_comb begin
    host_hit = 1'b0;
    host_pn  = '0;
    rx_hit   = 1'b0;
    rx_pn    = '0;
    free_cnt = '0;
    for (int i = NPAGE - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        host_hit = 1'b1;
        host_pn  = PN_W'(i);
      end
    end
    for (int i = 0; i < NPAGE; i++) free_cnt = free_cnt + CNT_W'(!used_q[i]);
    host_gnt = host_req & ~clr & host_hit;
    for (int i = NPAGE - 1; i >= 0; i--) begin
      if (!used_q[i] && !(host_gnt && host_pn == PN_W'(i))) begin
        rx_hit = 1'b1;
        rx_pn  = PN_W'(i);
      end
    end
    avail  = free_cnt - CNT_W'(host_gnt);
    rx_gnt = rx_req & ~clr & rx_hit & (avail > rsv);
    host_mask = '0;
    rx_mask   = '0;
    host_mask[host_pn] = host_gnt;
    rx_mask[rx_pn]     = rx_gnt;
    used_d = clr ? '0 : ((used_q & ~free_mask) | host_mask | rx_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  // R6: a receive grant never eats into the reserve it was checked against
  a_r6_reserve_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gnt |=> (free_cnt >= $past(rsv)));

  // R3: host and receive never receive the same page in one cycle
  a_r3_distinct_pages: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && rx_gnt && (host_pn == rx_pn)));
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pba_pkg::*;
#(
  parameter int NPAGE = 4,
  parameter int PN_W  = (NPAGE > 1) ? $clog2(NPAGE) : 1,
  parameter int CNT_W = $clog2(NPAGE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             pnr_we,
  input  logic [PN_W-1:0]  pnr_wdata,
  input  logic [CNT_W-1:0] rsv_pages,
  input  logic             auto_rel,
  input  logic             rx_req,
  input  logic             tx_done,
  output logic             busy,
  output logic [PN_W-1:0]  pnr_val,
  output logic [PN_W-1:0]  alloc_pnum,
  output logic             alloc_pend,
  output logic             int_alloc,
  output logic             int_rx,
  output logic             int_txe,
  output logic             rx_ack,
  output logic             rx_ok,
  output logic [PN_W-1:0]  rx_pnum,
  output logic             tx_empty,
  output logic [PN_W-1:0]  tx_head,
  output logic             done_empty,
  output logic [PN_W-1:0]  done_head,
  output logic             rx_empty,
  output logic [PN_W-1:0]  rx_head,
  output logic [CNT_W-1:0] mem_total,
  output logic [CNT_W-1:0] mem_free
);
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(NPAGE);

  host_op_e         cmd_q, cmd_d, exec_op;
  logic             busy_q, busy_d, pend_q, pend_d, ialloc_q, ialloc_d, txe_q, txe_d;
  logic [PN_W-1:0]  pnr_q, pnr_d, apn_q, apn_d, rxpn_q;
  logic             rxack_q, rxok_q;
  logic             is_clr, host_req, host_gnt, rx_gnt;
  logic [PN_W-1:0]  host_pn, rx_pn;
  logic [NPAGE-1:0] free_mask;
  logic             tx_full, tx_single, done_full, done_single, rx_full, rx_single;
  logic             rx_pop;

  assign exec_op  = busy_q ? cmd_q : OP_NOP;
  assign is_clr   = (exec_op == OP_RESET);
  assign host_req = pend_q | (exec_op == OP_ALLOC);
  assign rx_pop   = (exec_op == OP_RXPOP) | (exec_op == OP_RXPOPREL);

  always_comb begin
    for (int i = 0; i < NPAGE; i++) begin
      free_mask[i] = ((exec_op == OP_RELEASE) && (pnr_q == PN_W'(i)))
                   | ((exec_op == OP_RXPOPREL) && !rx_empty && (rx_head == PN_W'(i)))
                   | (tx_done && auto_rel && !tx_empty && (tx_head == PN_W'(i)));
    end
  end

  page_pool #(.NPAGE(NPAGE), .PN_W(PN_W), .CNT_W(CNT_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .clr(is_clr), .host_req(host_req), .rx_req(rx_req),
    .rsv(rsv_pages), .free_mask(free_mask), .host_gnt(host_gnt), .host_pn(host_pn),
    .rx_gnt(rx_gnt), .rx_pn(rx_pn), .free_cnt(mem_free)
  );

  pn_fifo #(.DEPTH(NPAGE), .W(PN_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(is_clr), .push(exec_op == OP_ENQUEUE), .pop(tx_done),
    .din(pnr_q), .dout(tx_head), .empty(tx_empty), .full(tx_full), .single(tx_single)
  );

  pn_fifo #(.DEPTH(NPAGE), .W(PN_W)) u_doneq (
    .clk(clk), .rst_n(rst_n), .clr(is_clr), .push(tx_done & ~tx_empty),
    .pop(exec_op == OP_DONEPOP), .din(tx_head), .dout(done_head), .empty(done_empty),
    .full(done_full), .single(done_single)
  );

  pn_fifo #(.DEPTH(NPAGE), .W(PN_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(is_clr), .push(rx_gnt), .pop(rx_pop),
    .din(rx_pn), .dout(rx_head), .empty(rx_empty), .full(rx_full), .single(rx_single)
  );

  always_comb begin
    busy_d   = ~busy_q & cmd_valid;
    cmd_d    = (~busy_q & cmd_valid) ? host_op_e'(cmd_op) : cmd_q;
    pend_d   = is_clr ? 1'b0 : (host_req & ~host_gnt);
    apn_d    = host_gnt ? host_pn : apn_q;
    ialloc_d = ialloc_q;
    if (is_clr)                      ialloc_d = 1'b0;
    else if (host_gnt)               ialloc_d = 1'b1;
    else if (exec_op == OP_ALLOC)    ialloc_d = 1'b0;
    txe_d = txe_q;
    if (is_clr)                                           txe_d = 1'b0;
    else if (tx_done && tx_single && exec_op != OP_ENQUEUE) txe_d = 1'b1;
    else if (exec_op == OP_ENQUEUE)                       txe_d = 1'b0;
    pnr_d = is_clr ? '0 : (pnr_we ? pnr_wdata : pnr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cmd_q    <= OP_NOP;
      pend_q   <= 1'b0;
      apn_q    <= '0;
      ialloc_q <= 1'b0;
      txe_q    <= 1'b0;
      pnr_q    <= '0;
      rxack_q  <= 1'b0;
      rxok_q   <= 1'b0;
      rxpn_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      cmd_q    <= cmd_d;
      pend_q   <= pend_d;
      apn_q    <= apn_d;
      ialloc_q <= ialloc_d;
      txe_q    <= txe_d;
      pnr_q    <= pnr_d;
      rxack_q  <= rx_req;
      rxok_q   <= rx_gnt;
      rxpn_q   <= rx_pn;
    end
  end

  assign busy       = busy_q;
  assign pnr_val    = pnr_q;
  assign alloc_pnum = apn_q;
  assign alloc_pend = pend_q;
  assign int_alloc  = ialloc_q;
  assign int_txe    = txe_q;
  assign int_rx     = ~rx_empty;
  assign rx_ack     = rxack_q;
  assign rx_ok      = rxok_q;
  assign rx_pnum    = rxpn_q;
  assign mem_total  = TOTAL;

  // R2: busy never lasts more than one cycle
  a_r2_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R2: an offered command while idle is taken
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R4: a waiting allocation resolves once a page is free
  a_r4_pend_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_pend && mem_free != '0) |=> !alloc_pend);

  // R7: a granted receive leaves a pending receive interrupt
  a_r7_rx_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && rx_ok) |-> int_rx);

  // R11: after the reset command every page is free
  a_r11_all_free: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_q == OP_RESET) |=> (mem_free == TOTAL && pnr_val == '0));
endmodule

// File: tb/sim_pkt_page_alloc.sv
module sim_pkt_page_alloc;
  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic pnr_we = 1'b0;
  logic [1:0] pnr_wdata = 2'd0;
  logic [2:0] rsv_pages = 3'd0;
  logic auto_rel = 1'b0;
  logic rx_req = 1'b0;
  logic tx_done = 1'b0;
  logic busy, alloc_pend, int_alloc, int_rx, int_txe, rx_ack, rx_ok;
  logic tx_empty, done_empty, rx_empty;
  logic [1:0] pnr_val, alloc_pnum, rx_pnum, tx_head, done_head, rx_head;
  logic [2:0] mem_total, mem_free;

  pkt_page_alloc u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pnr_we(pnr_we),
    .pnr_wdata(pnr_wdata), .rsv_pages(rsv_pages), .auto_rel(auto_rel), .rx_req(rx_req),
    .tx_done(tx_done), .busy(busy), .pnr_val(pnr_val), .alloc_pnum(alloc_pnum),
    .alloc_pend(alloc_pend), .int_alloc(int_alloc), .int_rx(int_rx), .int_txe(int_txe),
    .rx_ack(rx_ack), .rx_ok(rx_ok), .rx_pnum(rx_pnum), .tx_empty(tx_empty),
    .tx_head(tx_head), .done_empty(done_empty), .done_head(done_head),
    .rx_empty(rx_empty), .rx_head(rx_head), .mem_total(mem_total), .mem_free(mem_free)
  );

  always #(CLK_P / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit live = 1'b0;
  bit done_flag = 1'b0;
  int cyc = 0;

  // reference model state
  bit m_used [4];
  int m_txq[$];
  int m_rxq[$];
  int m_dq[$];
  int m_pnr = 0, m_apn = 0, m_cmd = 0, m_rxpn = 0;
  bit m_busy = 0, m_pend = 0, m_ialloc = 0, m_txe = 0, m_ack = 0, m_ok = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_free();
    int n = 0;
    for (int i = 0; i < 4; i++) if (!m_used[i]) n++;
    return n;
  endfunction

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_used[i] = 0;
      m_txq.delete(); m_rxq.delete(); m_dq.delete();
      m_pnr = 0; m_apn = 0; m_cmd = 0; m_rxpn = 0;
      m_busy = 0; m_pend = 0; m_ialloc = 0; m_txe = 0; m_ack = 0; m_ok = 0;
    end else begin
      int ex, hp, rp, nf, popped, txs, dqs, rxs;
      bit clr, hreq, hg, rg, rfound, txpop, dpop, rpop;
      bit fr [4];
      ex = m_busy ? m_cmd : 0;
      clr = (ex == 2);
      hreq = !clr && (m_pend || ex == 1);
      nf = m_free();
      hg = 0; hp = 0;
      if (hreq) for (int i = 3; i >= 0; i--) if (!m_used[i]) begin hg = 1; hp = i; end
      rfound = 0; rp = 0;
      for (int i = 3; i >= 0; i--)
        if (!m_used[i] && !(hg && i == hp)) begin rfound = 1; rp = i; end
      rg = rx_req && !clr && rfound && ((nf - int'(hg)) > int'(rsv_pages));
      for (int i = 0; i < 4; i++) fr[i] = 0;
      if (ex == 5) fr[m_pnr] = 1;
      if (ex == 4 && m_rxq.size() > 0) fr[m_rxq[0]] = 1;
      if (tx_done && auto_rel && m_txq.size() > 0) fr[m_txq[0]] = 1;
      txs = m_txq.size(); dqs = m_dq.size(); rxs = m_rxq.size();
      txpop = tx_done && txs > 0;
      popped = txpop ? m_txq[0] : 0;
      if (clr) begin
        for (int i = 0; i < 4; i++) m_used[i] = 0;
        m_txq.delete(); m_rxq.delete(); m_dq.delete();
        m_pnr = 0; m_pend = 0; m_ialloc = 0; m_txe = 0;
      end else begin
        for (int i = 0; i < 4; i++) if (fr[i]) m_used[i] = 0;
        if (hg) m_used[hp] = 1;
        if (rg) m_used[rp] = 1;
        if (txpop) void'(m_txq.pop_front());
        if (ex == 6 && (txs < 4 || txpop)) m_txq.push_back(m_pnr);
        dpop = (ex == 7 && dqs > 0);
        if (dpop) void'(m_dq.pop_front());
        if (txpop && (dqs < 4 || dpop)) m_dq.push_back(popped);
        rpop = ((ex == 3 || ex == 4) && rxs > 0);
        if (rpop) void'(m_rxq.pop_front());
        if (rg && (rxs < 4 || rpop)) m_rxq.push_back(rp);
        if (txpop && txs == 1 && ex != 6) m_txe = 1;
        else if (ex == 6) m_txe = 0;
        if (hg) begin m_ialloc = 1; m_apn = hp; end
        else if (ex == 1) m_ialloc = 0;
        m_pend = hreq && !hg;
        if (pnr_we) m_pnr = int'(pnr_wdata);
      end
      m_ack = rx_req; m_ok = rg; m_rxpn = rp;
      if (!m_busy && cmd_valid) m_cmd = int'(cmd_op);
      m_busy = !m_busy && cmd_valid;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(int'(mem_free) == m_free(), "R5 mem_free", mem_free, m_free());
      chk(mem_total == 3'd4, "R5 mem_total", mem_total, 4);
      chk(int_alloc == m_ialloc, "R3 int_alloc", int_alloc, m_ialloc);
      if (m_ialloc) chk(int'(alloc_pnum) == m_apn, "R3 alloc_pnum", alloc_pnum, m_apn);
      chk(alloc_pend == m_pend, "R4 alloc_pend", alloc_pend, m_pend);
      chk(int_rx == (m_rxq.size() > 0), "R7 int_rx", int_rx, m_rxq.size() > 0);
      chk(rx_empty == (m_rxq.size() == 0), "R10 rx_empty", rx_empty, m_rxq.size() == 0);
      if (m_rxq.size() > 0) chk(int'(rx_head) == m_rxq[0], "R10 rx_head", rx_head, m_rxq[0]);
      chk(tx_empty == (m_txq.size() == 0), "R8 tx_empty", tx_empty, m_txq.size() == 0);
      if (m_txq.size() > 0) chk(int'(tx_head) == m_txq[0], "R8 tx_head", tx_head, m_txq[0]);
      chk(done_empty == (m_dq.size() == 0), "R8 done_empty", done_empty, m_dq.size() == 0);
      if (m_dq.size() > 0) chk(int'(done_head) == m_dq[0], "R8 done_head", done_head, m_dq[0]);
      chk(int_txe == m_txe, "R12 int_txe", int_txe, m_txe);
      chk(int'(pnr_val) == m_pnr, "R13 pnr_val", pnr_val, m_pnr);
      chk(rx_ack == m_ack, "R6 rx_ack", rx_ack, m_ack);
      chk(rx_ok == m_ok, "R6 rx_ok", rx_ok, m_ok);
      if (m_ok) chk(int'(rx_pnum) == m_rxpn, "R6 rx_pnum", rx_pnum, m_rxpn);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done_flag) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_LIMIT);
      report();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(input int op);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wr_pnr(input int v);
    pnr_we = 1'b1; pnr_wdata = 2'(v);
    @(negedge clk);
    pnr_we = 1'b0;
  endtask

  task automatic pulse_tx();
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic pulse_rx();
    rx_req = 1'b1; @(negedge clk); rx_req = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    live = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(mem_free == 3'd4, "R1 free", mem_free, 4);
    chk(mem_total == 3'd4, "R1 total", mem_total, 4);
    chk(tx_empty && rx_empty && done_empty, "R1 queues", {tx_empty, rx_empty, done_empty}, 7);
    chk(!busy && pnr_val == 2'd0, "R1 busy_pnr", {busy, pnr_val}, 0);
    chk(!int_alloc && !int_rx && !int_txe && !alloc_pend, "R1 irq",
        {int_alloc, int_rx, int_txe, alloc_pend}, 0);

    // transmit path, pages kept after completion (R9 with auto_rel low)
    cmd(1); idle(1); wr_pnr(m_apn); cmd(6);
    cmd(1); idle(1); wr_pnr(m_apn); cmd(6);
    idle(1);
    pulse_tx(); idle(1);
    pulse_tx(); idle(1);
    chk(mem_free == 3'd2, "R9 kept", mem_free, 2);
    chk(int_txe == 1'b1, "R12 txe", int_txe, 1);
    cmd(7); cmd(7);
    wr_pnr(0); cmd(5); wr_pnr(1); cmd(5); idle(1);

    // exhaust pool, pending alloc, denied receive (R4)
    for (int k = 0; k < 4; k++) begin cmd(1); idle(1); end
    cmd(1); idle(2);
    chk(alloc_pend == 1'b1, "R4 pend", alloc_pend, 1);
    pulse_rx(); idle(2);
    wr_pnr(2); cmd(5); idle(3);
    chk(alloc_pend == 1'b0 && int_alloc, "R4 granted", alloc_pend, 0);

    // reset command (R11)
    cmd(2); idle(1);
    chk(mem_free == 3'd4 && pnr_val == 2'd0, "R11 clean", mem_free, 4);

    // reserve (R6) and receive removal (R10)
    rsv_pages = 3'd2;
    pulse_rx(); idle(1); pulse_rx(); idle(1); pulse_rx(); idle(1);
    cmd(3); idle(1);
    cmd(4); idle(1);
    wr_pnr(0); cmd(5); idle(1);
    rsv_pages = 3'd0;

    // host and receive in the same cycle (R3)
    cmd_valid = 1'b1; cmd_op = 3'd1; @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; rx_req = 1'b1; @(negedge clk);
    rx_req = 1'b0; idle(2);

    // auto release on completion (R9)
    auto_rel = 1'b1;
    wr_pnr(m_apn); cmd(6); idle(1);
    pulse_tx(); idle(1);
    chk(int'(mem_free) == m_free(), "R9 auto", mem_free, m_free());
    cmd(7); idle(1);

    // command offered while busy is dropped (R2), queue overflow (R8)
    auto_rel = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd6; @(negedge clk); @(negedge clk);
    cmd_valid = 1'b0; idle(2);
    for (int k = 0; k < 5; k++) cmd(6);
    idle(1);
    for (int k = 0; k < 6; k++) begin pulse_tx(); end
    idle(2);

    // reset command with a concurrent receive request and pnr write (R11, R13)
    cmd_valid = 1'b1; cmd_op = 3'd2; @(negedge clk);
    cmd_valid = 1'b0; rx_req = 1'b1; pnr_we = 1'b1; pnr_wdata = 2'd3; @(negedge clk);
    rx_req = 1'b0; pnr_we = 1'b0; idle(2);
    chk(rx_empty && done_empty && tx_empty, "R11 queues", {rx_empty, done_empty, tx_empty}, 7);
    idle(2);
    report();
  end
endmodule